// File: doc/BRIEF.md
# Compare-Match Tick Timer

The block keeps a free-running tick counter and two compare registers, one for a supervisor timer channel and one for a hypervisor timer channel. Software writes a compare register with a target count. If that target is still ahead of the counter and the register's top bit is clear, the channel is armed. When the counter reaches the target, the channel gives a one-cycle match pulse and sets its sticky flag. For the supervisor channel this flag is bit 16 of the soft-interrupt word. For the hypervisor channel it is an interrupt-pending flag.

The top bit of each 64-bit compare register disables its channel, and only the lower bits take part in the comparison. While the thread-halted input is high, the hypervisor channel cannot produce a match. The counter and the compare registers are readable through a select-addressed read port. The two flags are readable and writable through the same select codes.

Top module: `tick_cmp_timer`

## Requirements
- R1: The counter reads 0 after reset and rises by one on every clock. It wraps from all ones (CNT_W bits) back to 0.
- R2: Select codes are 0 = counter, 1 = supervisor compare, 2 = hypervisor compare, 3 = soft-interrupt word, 4 = hypervisor pending. A compare register reads back the full 64-bit value last written. After reset a compare register reads with bit 63 set and bits 62:0 zero. Writes to select 0 are ignored.
- R3: A write with bit 63 clear and a value in bits 62:0 greater than the counter arms the channel. The match pulse is high for exactly one cycle, and only in the cycle where the counter equals that value.
- R4: A compare write whose value is not greater than the counter at the write edge never produces a pulse.
- R5: A compare write with bit 63 set produces no pulse. It also cancels a match armed by an earlier write to the same register.
- R6: A supervisor pulse sets the soft-interrupt flag one cycle later. The flag reads as bit 16 of select 3 and stays set until a write to select 3 with bit 16 clear. If a pulse and a clearing write fall in the same cycle, the pulse wins.
- R7: A hypervisor pulse sets the hypervisor pending flag one cycle later. The flag reads as bit 0 of select 4 and stays set until a write to select 4 with bit 0 clear. If a pulse and a clearing write fall in the same cycle, the pulse wins.
- R8: While the thread-halted input is high, the hypervisor channel gives no pulse. A match suppressed this way is consumed and does not fire later.
- R9: Each compare write fires at most once.
- R10: A new compare write re-arms a channel that has already fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Write select code |
| wrData | input | DATA_W | Write data |
| rdSel | input | 3 | Read select code |
| rdData | output | DATA_W | Read data, combinational on rdSel |
| threadHalted | input | 1 | Thread halted; suppresses hypervisor matches |
| supMatch | output | 1 | Supervisor one-cycle match pulse |
| hypMatch | output | 1 | Hypervisor one-cycle match pulse |
| softTickPend | output | 1 | Soft-interrupt bit 16 flag |
| hypIntPend | output | 1 | Hypervisor interrupt-pending flag |

## Verification
The embedded properties check, on every cycle, the following: the counter step, that each pulse sets its flag one cycle later, that a flag holds until it is cleared by a write, that a pulse never repeats in the next cycle, and that a disabling write blocks a pulse in the following cycle. Only the directed scenarios can show the rest. These cover the exact cycle at which a pulse appears relative to the write, the refusal to arm on past or equal targets, the cancellation of an earlier armed match, the consumption of a match suppressed by halt, read-back values and wrap-around.

// File: rtl/tick_pkg.sv
package tick_pkg;

  typedef enum logic [2:0] {
    SEL_COUNT = 3'd0,
    SEL_SUP   = 3'd1,
    SEL_HYP   = 3'd2,
    SEL_SOFT  = 3'd3,
    SEL_HPEND = 3'd4
  } regSel_e;

  typedef struct packed {
    logic ldSup;
    logic ldHyp;
  } cmpStrobes_t;

endpackage

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmpStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] supCmp,
  output logic [DATA_W-1:0] hypCmp,
  output logic              supEq,
  output logic              hypEq,
  output logic              wrLater
);
  localparam int VAL_W = DATA_W - 1;
  localparam logic [DATA_W-1:0] CMP_RESET = {1'b1, {VAL_W{1'b0}}};

  logic [VAL_W-1:0] countExt;
  assign countExt = VAL_W'(count);

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      supCmp <= CMP_RESET;
      hypCmp <= CMP_RESET;
    end else begin
      if (strobes.ldSup) supCmp <= wrData;
      if (strobes.ldHyp) hypCmp <= wrData;
    end
  end

  assign supEq   = (supCmp[VAL_W-1:0] == countExt);
  assign hypEq   = (hypCmp[VAL_W-1:0] == countExt);
  assign wrLater = (wrData[VAL_W-1:0] > countExt);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> count == CNT_W'($past(count) + 1'b1));

endmodule

// File: rtl/tick_control.sv
module tick_control
  import tick_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SOFT_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              threadHalted,
  input  logic              supEq,
  input  logic              hypEq,
  input  logic              wrLater,
  output cmpStrobes_t       strobes,
  output logic              supMatch,
  output logic              hypMatch,
  output logic              softTickPend,
  output logic              hypIntPend
);
  localparam int DIS_BIT = DATA_W - 1;

  regSel_e sel;
  logic    armOk;
  logic    supArmed, hypArmed;
  logic    ldSoft, ldHpend;

  assign sel           = regSel_e'(wrSel);
  assign strobes.ldSup = wrEn && (sel == SEL_SUP);
  assign strobes.ldHyp = wrEn && (sel == SEL_HYP);
  assign ldSoft        = wrEn && (sel == SEL_SOFT);
  assign ldHpend       = wrEn && (sel == SEL_HPEND);
  assign armOk         = !wrData[DIS_BIT] && wrLater;

  assign supMatch = supArmed && supEq;
  assign hypMatch = hypArmed && hypEq && !threadHalted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      supArmed <= 1'b0;
      hypArmed <= 1'b0;
    end else begin
      if (strobes.ldSup)  supArmed <= armOk;
      else if (supEq)     supArmed <= 1'b0;
      if (strobes.ldHyp)  hypArmed <= armOk;
      else if (hypEq)     hypArmed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      softTickPend <= 1'b0;
      hypIntPend   <= 1'b0;
    end else begin
      if (supMatch)     softTickPend <= 1'b1;
      else if (ldSoft)  softTickPend <= wrData[SOFT_BIT];
      if (hypMatch)     hypIntPend   <= 1'b1;
      else if (ldHpend) hypIntPend   <= wrData[0];
    end
  end

  // R6
  sup_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    supMatch |=> softTickPend);
  // R7
  hyp_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    hypMatch |=> hypIntPend);
  // R7
  hyp_flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hypIntPend && !ldHpend) |=> hypIntPend);
  // R9
  sup_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    supMatch |=> !supMatch);
  // R9
  hyp_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    hypMatch |=> !hypMatch);
  // R5
  sup_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ldSup && wrData[DIS_BIT]) |=> !supMatch);

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tick_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int CNT_W    = 63,
  parameter int SOFT_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdSel,
  output logic [DATA_W-1:0] rdData,
  input  logic              threadHalted,
  output logic              supMatch,
  output logic              hypMatch,
  output logic              softTickPend,
  output logic              hypIntPend
);
  cmpStrobes_t       strobes;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] supCmp, hypCmp;
  logic              supEq, hypEq, wrLater;

  tick_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .count(count), .supCmp(supCmp), .hypCmp(hypCmp),
    .supEq(supEq), .hypEq(hypEq), .wrLater(wrLater)
  );

  tick_control #(.DATA_W(DATA_W), .SOFT_BIT(SOFT_BIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .threadHalted(threadHalted), .supEq(supEq), .hypEq(hypEq),
    .wrLater(wrLater), .strobes(strobes), .supMatch(supMatch),
    .hypMatch(hypMatch), .softTickPend(softTickPend), .hypIntPend(hypIntPend)
  );

  always_comb begin
    rdData = '0;
    case (regSel_e'(rdSel))
      SEL_COUNT: rdData = DATA_W'(count);
      SEL_SUP:   rdData = supCmp;
      SEL_HYP:   rdData = hypCmp;
      SEL_SOFT:  rdData[SOFT_BIT] = softTickPend;
      SEL_HPEND: rdData[0] = hypIntPend;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: tb/test_tick_cmp_timer.sv
module test_tick_cmp_timer;
  import tick_pkg::*;

  localparam int DATA_W = 64;
  localparam int CNT_W  = 12;
  localparam logic [63:0] DIS = 64'h1 << 63;
  localparam longint WRAP = 1 << CNT_W;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, threadHalted = 1'b0;
  logic [2:0] wrSel = '0, rdSel = '0;
  logic [DATA_W-1:0] wrData = '0, rdData;
  logic supMatch, hypMatch, softTickPend, hypIntPend;
  int testCnt = 0, failCnt = 0;

  always #10 clk = ~clk;

  tick_cmp_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SOFT_BIT(16)) i_tick_cmp_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .threadHalted(threadHalted),
    .supMatch(supMatch), .hypMatch(hypMatch),
    .softTickPend(softTickPend), .hypIntPend(hypIntPend)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] s, output logic [63:0] v);
    rdSel = s; #1; v = rdData; rdSel = 3'(SEL_COUNT); #1;
  endtask

  task automatic curCount(output longint c);
    #1; c = longint'(rdData);
  endtask

  // Call at a negedge; returns at the next negedge, after the write edge.
  task automatic doWrite(input logic [2:0] s, input logic [63:0] d);
    wrEn = 1'b1; wrSel = s; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  // Index 1 is the negedge right after the write; 0 means no pulse expected.
  task automatic watch(input int n, input int kSup, input int kHyp, input string tag);
    longint prev = -1;
    for (int i = 1; i <= n; i++) begin
      longint c;
      curCount(c);
      if (prev >= 0) chk(c == (prev + 1) % WRAP, {"R1 step ", tag}, c, (prev + 1) % WRAP);
      chk(supMatch == (i == kSup), {"R3/R9 sup ", tag}, supMatch, i == kSup);
      chk(hypMatch == (i == kHyp), {"R3/R8 hyp ", tag}, hypMatch, i == kHyp);
      prev = c;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [63:0] v;
    longint c;
    curCount(c);
    chk(c <= 1, "R1 reset count", c, 0);
    readReg(3'(SEL_SUP), v); chk(v == DIS, "R2 reset sup cmp", v, DIS);
    readReg(3'(SEL_HYP), v); chk(v == DIS, "R2 reset hyp cmp", v, DIS);
    chk(!softTickPend && !hypIntPend, "R6 R7 reset flags", softTickPend, 0);
  endtask

  task automatic t_readback;
    logic [63:0] v;
    longint c;
    doWrite(3'(SEL_SUP), DIS | 64'h123);
    readReg(3'(SEL_SUP), v); chk(v == (DIS | 64'h123), "R2 sup readback", v, DIS | 64'h123);
    doWrite(3'(SEL_HYP), DIS | 64'h5A5);
    readReg(3'(SEL_HYP), v); chk(v == (DIS | 64'h5A5), "R2 hyp readback", v, DIS | 64'h5A5);
    curCount(c);
    doWrite(3'(SEL_COUNT), 64'h0);
    curCount(v);
    chk(longint'(v) == c + 1, "R2 counter write ignored", v, c + 1);
  endtask

  task automatic t_supMatch;
    logic [63:0] v;
    longint c;
    curCount(c);
    doWrite(3'(SEL_SUP), 64'(c + 5));
    watch(12, 5, 0, "sup match");
    chk(softTickPend, "R6 soft flag set", softTickPend, 1);
    readReg(3'(SEL_SOFT), v); chk(v == 64'h10000, "R6 soft bit16 read", v, 64'h10000);
    doWrite(3'(SEL_SOFT), 64'h0);
    chk(!softTickPend, "R6 soft flag cleared", softTickPend, 0);
  endtask

  task automatic t_past;
    longint c;
    curCount(c);
    doWrite(3'(SEL_SUP), 64'(c));
    watch(10, 0, 0, "equal value");
    curCount(c);
    doWrite(3'(SEL_SUP), 64'(c - 1));
    watch(10, 0, 0, "past value");
    chk(!softTickPend, "R4 no flag", softTickPend, 0);
  endtask

  task automatic t_disable;
    longint c;
    curCount(c);
    doWrite(3'(SEL_SUP), DIS | 64'(c + 4));
    watch(8, 0, 0, "disabled write");
    curCount(c);
    doWrite(3'(SEL_SUP), 64'(c + 10));
    doWrite(3'(SEL_SUP), DIS | 64'(c + 10));
    watch(14, 0, 0, "cancelled arm");
    chk(!softTickPend, "R5 no flag after cancel", softTickPend, 0);
  endtask

  task automatic t_hyp;
    longint c;
    curCount(c);
    doWrite(3'(SEL_HYP), 64'(c + 6));
    watch(10, 0, 6, "hyp match");
    chk(hypIntPend, "R7 pending set", hypIntPend, 1);
    repeat (5) @(negedge clk);
    chk(hypIntPend, "R7 pending holds", hypIntPend, 1);
    doWrite(3'(SEL_HPEND), 64'h0);
    chk(!hypIntPend, "R7 pending cleared", hypIntPend, 0);
  endtask

  task automatic t_halt;
    longint c;
    threadHalted = 1'b1;
    curCount(c);
    doWrite(3'(SEL_HYP), 64'(c + 3));
    watch(8, 0, 0, "halted");
    chk(!hypIntPend, "R8 no pending while halted", hypIntPend, 0);
    threadHalted = 1'b0;
    watch(6, 0, 0, "after halt");
    chk(!hypIntPend, "R8 match consumed", hypIntPend, 0);
  endtask

  task automatic t_rearm;
    longint c;
    curCount(c);
    doWrite(3'(SEL_SUP), 64'(c + 3));
    watch(5, 3, 0, "first arm");
    curCount(c);
    doWrite(3'(SEL_SUP), 64'(c + 4));
    watch(8, 4, 0, "R10 rearm");
    doWrite(3'(SEL_SOFT), 64'h0);
  endtask

  task automatic t_wrap;
    longint c = 0;
    for (int i = 0; i < 2 * WRAP && c != WRAP - 1; i++) begin
      @(negedge clk);
      curCount(c);
    end
    chk(c == WRAP - 1, "R1 reached all ones", c, WRAP - 1);
    @(negedge clk);
    curCount(c);
    chk(c == 0, "R1 wrap to zero", c, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_readback();
    t_supMatch();
    t_past();
    t_disable();
    t_hyp();
    t_halt();
    t_rearm();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule